// File: doc/BRIEF.md
# Flip-Flop State Capture Trigger

This block turns a user capture request into the internal strobe that snapshots design state for later readback. The request is brought into the block's clock domain through a synchronizer, and the synchronized level feeds a registered strobe. The user logic decides when captures happen by driving the request. A lockout input keeps captures away from the times when error scanning of the stored state is running.

There are two modes. In continuous mode the strobe copies the synchronized request, one register later. In one-shot mode the block disarms itself when the synchronized request first falls, and after that it ignores every further request until a re-arm command arrives. The armed flag is visible at the ports, so software or a sequencer can see whether a one-shot capture is still pending.

Top module: `capture_trigger`

## Requirements
- R1: After reset is released, `cap_strobe_o` is 0 and `armed_o` is 1, and the active mode is continuous.
- R2: In continuous mode (`oneshot_i` = 0), `cap_strobe_o` equals the value of `cap_req_i` from SYNC_STAGES+1 rising clock edges earlier (3 edges by default). Nothing else delays or changes it.
- R3: In one-shot mode (`oneshot_i` = 1), the strobe follows the request while the block is armed. On the edge after the synchronized request falls, `armed_o` drops to 0. From then on `cap_strobe_o` stays 0 whatever `cap_req_i` does.
- R4: When `rearm_i` is 1 at a rising edge, `armed_o` is 1 after that edge. The next request then produces a strobe in one-shot mode.
- R5: If `rearm_i` and a falling edge of the synchronized request arrive in the same cycle, re-arm wins and `armed_o` stays 1.
- R6: When `lockout_i` is 1 at a rising edge, `cap_strobe_o` is 0 after that edge. Once the lockout is released, the strobe resumes following the request on the next edge.
- R7: A change on `oneshot_i` is taken up only at an edge where the synchronized request is low. While the request is held high, the mode in use does not change.
- R8: In continuous mode, falling edges of the request leave `armed_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_req_i | input | 1 | Active-high capture request; may be asynchronous |
| oneshot_i | input | 1 | Mode select: 0 = continuous, 1 = one-shot |
| rearm_i | input | 1 | Re-arm command for one-shot mode, sampled each edge |
| lockout_i | input | 1 | Suppresses the strobe while error scanning is active |
| cap_strobe_o | output | 1 | Internal capture strobe; state is captured while high |
| armed_o | output | 1 | 1 while a one-shot capture can still fire |

## Verification
The disarm caused by a falling request and the re-arm command can both occur in the same cycle. The bench provokes this by dropping the request and then raising `rearm_i` for exactly the cycle in which the synchronized level has just fallen. It judges the result by checking that `armed_o` stays 1 and that a later request still produces a strobe. Lockout and a live request also overlap: the bench holds the request high while pulsing the lockout, and expects the strobe to drop for exactly the edges during which the lockout was sampled high.

// File: rtl/cap_trig_pkg.sv
package cap_trig_pkg;

    typedef enum logic {
        MODE_CONT    = 1'b0,
        MODE_ONESHOT = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic      armed;
        cap_mode_e mode;
    } arm_state_t;

    typedef struct packed {
        logic strobe;
    } out_state_t;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~lvl_i;

    // R3: a detected fall means the level was high one edge earlier
    p_fall_hist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(lvl_i));
endmodule

// File: rtl/cap_arm.sv
module cap_arm
    import cap_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_s_i,
    input  logic      fall_i,
    input  logic      rearm_i,
    input  logic      mode_sel_i,
    output logic      armed_o,
    output cap_mode_e mode_o
);
    arm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!req_s_i)
            st_d.mode = mode_sel_i ? MODE_ONESHOT : MODE_CONT;
        if (rearm_i)
            st_d.armed = 1'b1;
        else if (fall_i && st_q.mode == MODE_ONESHOT)
            st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1, mode: MODE_CONT};
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign mode_o  = st_q.mode;

    p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> armed_o);

    p_fall_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && mode_o == MODE_ONESHOT && !rearm_i) |=> !armed_o);

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_s_i |=> $stable(mode_o));

    p_cont_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_CONT && !rearm_i) |=> $stable(armed_o));
endmodule

// File: rtl/capture_trigger.sv
module capture_trigger
    import cap_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_req_i,
    input  logic oneshot_i,
    input  logic rearm_i,
    input  logic lockout_i,
    output logic cap_strobe_o,
    output logic armed_o
);
    logic       req_s;
    logic       req_fall;
    logic       armed;
    cap_mode_e  mode;
    out_state_t out_d, out_q;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cap_req_i), .q_o(req_s)
    );

    cap_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(req_s), .fall_o(req_fall)
    );

    cap_arm u_arm (
        .clk(clk), .rst_n(rst_n), .req_s_i(req_s), .fall_i(req_fall),
        .rearm_i(rearm_i), .mode_sel_i(oneshot_i),
        .armed_o(armed), .mode_o(mode)
    );

    always_comb begin
        out_d = out_q;
        out_d.strobe = req_s && !lockout_i && (mode == MODE_CONT || armed);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cap_strobe_o = out_q.strobe;
    assign armed_o      = armed;

    p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_i |=> !cap_strobe_o);

    p_disarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ONESHOT && !armed) |=> !cap_strobe_o);

    p_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_s |=> !cap_strobe_o);
endmodule

// File: tb/capture_trigger_tb.sv
module capture_trigger_tb;
    localparam int CLK_P = 10;
    localparam int LAT   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_req = 1'b0, oneshot = 1'b0, rearm = 1'b0, lockout = 1'b0;
    logic strobe, armed;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    capture_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .cap_req_i(cap_req), .oneshot_i(oneshot),
        .rearm_i(rearm), .lockout_i(lockout),
        .cap_strobe_o(strobe), .armed_o(armed)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        cap_req = 0; oneshot = 0; rearm = 0; lockout = 0;
        rst_n = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    task automatic enter_oneshot();
        oneshot = 1;
        tick(2);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 strobe after reset", strobe, 1'b0);
        check("R1 armed after reset", armed, 1'b1);
        cap_req = 1;
        tick(LAT);
        check("R1 default mode continuous", strobe, 1'b1);
    endtask

    task automatic t_continuous();
        logic [19:0] pat = 20'b1011_0011_1000_1101_0110;
        logic [19:0] sent = '0;
        do_reset();
        for (int i = 0; i < 20; i++) begin
            cap_req = pat[i];
            sent[i] = pat[i];
            tick(1);
            if (i >= 2) check("R2 continuous tracks request", strobe, sent[i-2]);
        end
        cap_req = 0;
        tick(LAT);
        check("R8 armed kept in continuous", armed, 1'b1);
        check("R2 strobe low after request low", strobe, 1'b0);
    endtask

    task automatic t_oneshot();
        do_reset();
        enter_oneshot();
        cap_req = 1;
        tick(LAT - 1);
        check("R3 strobe not yet up", strobe, 1'b0);
        tick(1);
        check("R3 first strobe fires", strobe, 1'b1);
        check("R3 still armed while high", armed, 1'b1);
        cap_req = 0;
        tick(LAT);
        check("R3 disarmed after fall", armed, 1'b0);
        check("R3 strobe low after fall", strobe, 1'b0);
        cap_req = 1;
        tick(LAT + 3);
        check("R3 later request ignored", strobe, 1'b0);
        cap_req = 0;
        tick(LAT);
    endtask

    task automatic t_rearm();
        rearm = 1;
        tick(1);
        rearm = 0;
        check("R4 armed after rearm", armed, 1'b1);
        cap_req = 1;
        tick(LAT);
        check("R4 strobe after rearm", strobe, 1'b1);
        cap_req = 0;
        tick(LAT);
        check("R4 disarmed again", armed, 1'b0);
    endtask

    task automatic t_collision();
        rearm = 1;
        tick(1);
        rearm = 0;
        cap_req = 1;
        tick(LAT + 1);
        cap_req = 0;
        tick(2);
        rearm = 1;
        tick(1);
        rearm = 0;
        check("R5 rearm beats fall", armed, 1'b1);
        tick(2);
        check("R5 remains armed", armed, 1'b1);
        cap_req = 1;
        tick(LAT);
        check("R5 strobe after collision", strobe, 1'b1);
        cap_req = 0;
        tick(LAT);
    endtask

    task automatic t_lockout();
        do_reset();
        cap_req = 1;
        tick(LAT);
        check("R6 strobe before lockout", strobe, 1'b1);
        lockout = 1;
        tick(1);
        check("R6 strobe suppressed", strobe, 1'b0);
        tick(2);
        check("R6 strobe held low", strobe, 1'b0);
        lockout = 0;
        tick(1);
        check("R6 strobe resumes", strobe, 1'b1);
        cap_req = 0;
        tick(LAT);
    endtask

    task automatic t_mode_change();
        do_reset();
        enter_oneshot();
        cap_req = 1;
        tick(LAT + 1);
        cap_req = 0;
        tick(LAT);
        check("R7 setup disarmed", armed, 1'b0);
        cap_req = 1;
        tick(LAT);
        oneshot = 0;
        tick(4);
        check("R7 mode held while request high", strobe, 1'b0);
        cap_req = 0;
        tick(LAT + 1);
        cap_req = 1;
        tick(LAT);
        check("R7 continuous after request low", strobe, 1'b1);
        check("R8 armed unchanged", armed, 1'b0);
        cap_req = 0;
        tick(LAT);
    endtask

    initial begin
        t_reset();
        t_continuous();
        t_oneshot();
        t_rearm();
        t_collision();
        t_lockout();
        t_mode_change();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule